// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Arbiter

This block decides which mailbox of a transmit bank is handed next to a bit-level CAN engine. Every mailbox carries an enable bit, a direction bit, a pending-request bit and a priority value. Whenever the engine is idle, the block looks at all mailboxes that may send, picks the one with the largest priority value, and holds that mailbox index steady until the engine reports that the frame went out or was aborted. Among mailboxes with equal priority, the one with the highest number goes first.

The host reaches the bank through a single write port. A 3-bit selector chooses the target: enable register, direction register, request-set register, acknowledge-clear register, abort-acknowledge-clear register, or the control word of one mailbox. The request, acknowledge and abort-acknowledge vectors are visible on output ports. The engine side is a level `grant_valid` with `grant_idx`, plus one-cycle `eng_done` and `eng_abort` pulses.

Top module: `can_tx_arbiter`

## Requirements
- R1: A mailbox can be granted only if all three hold: its enable bit is 1 (selector 0), its direction bit is 0 (selector 1, where 1 means receive), and its request is pending.
- R2: Among eligible mailboxes, the grant goes to the one with the largest priority. Each mailbox's priority is taken from bits 13:8 of its control word (selector 5, mailbox chosen by `cfg_idx`).
- R3: If several eligible mailboxes share the largest priority, the highest-numbered one is granted.
- R4: An `eng_done` pulse during a grant sets that mailbox's acknowledge bit and clears its request.
- R5: A write with selector 3 clears each acknowledge bit written as 1. Bits written as 0 leave their acknowledge bits unchanged.
- R6: A write with selector 2 sets each request bit written as 1. Bits written as 0 leave their request bits unchanged.
- R7: An `eng_abort` pulse during a grant sets that mailbox's abort-acknowledge bit, clears its request, and leaves its acknowledge bit alone. If `eng_done` and `eng_abort` arrive together, the pulse counts as a done. A write with selector 4 clears each abort-acknowledge bit written as 1.
- R8: `grant_valid` and `grant_idx` stay unchanged for the whole frame, even if priorities, enables or requests change during it.
- R9: `grant_valid` stays low while no mailbox is eligible. After every done or abort it is low for at least one cycle before the next grant.
- R10: When a host write and a completion hit the same bit in the same cycle, the set wins. A request-set write survives the completion's request clear. A completion's acknowledge set survives an acknowledge-clear write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Host write strobe |
| cfg_sel | input | 3 | Write target: 0 enable, 1 direction, 2 request set, 3 ack clear, 4 abort-ack clear, 5 control word |
| cfg_idx | input | IDX_W | Mailbox number for a control-word write |
| cfg_wdata | input | NUM_MBOX | Write data |
| eng_done | input | 1 | Engine reports the granted frame was sent |
| eng_abort | input | 1 | Engine reports the granted frame was aborted |
| grant_valid | output | 1 | A mailbox is granted to the engine |
| grant_idx | output | IDX_W | Number of the granted mailbox |
| req_flags | output | NUM_MBOX | Pending transmit requests |
| ack_flags | output | NUM_MBOX | Transmit acknowledge flags |
| abt_flags | output | NUM_MBOX | Abort acknowledge flags |

## Verification
A frame completion and a host write can land on the same mailbox bit in the same cycle. In that case the completion clears the request while the host sets it, or the completion sets the acknowledge while the host clears it. The bench provokes this by raising `eng_done` in the very cycle that a request-set or acknowledge-clear write for the granted mailbox is presented. It then judges the outcome at the ports: the request must stay pending and the same mailbox must be granted again, and afterwards the acknowledge bit must still read 1 even though the host cleared it in the completion cycle.

// File: rtl/can_tx_arb_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the transmit mailbox arbiter.
// Assumes the host data word is wide enough to hold the control-word
// priority field at PRIO_LSB.
package can_tx_arb_pkg;

    // Host write targets selected by cfg_sel.
    typedef enum logic [2:0] {
        SEL_ENABLE  = 3'd0,
        SEL_DIR     = 3'd1,
        SEL_REQ_SET = 3'd2,
        SEL_ACK_CLR = 3'd3,
        SEL_ABT_CLR = 3'd4,
        SEL_CTRL    = 3'd5
    } cfg_sel_e;

    // Grant sequencer states.
    typedef enum logic {
        GS_IDLE = 1'b0,
        GS_BUSY = 1'b1
    } grant_state_e;

    // Lowest bit of the priority field inside a control word.
    localparam int PRIO_LSB = 8;

endpackage

// File: rtl/can_tx_mbox_bank.sv
`timescale 1ns/1ps
// Module: mailbox state bank. Holds enable, direction, request,
// acknowledge, abort-acknowledge and priority for every mailbox, and
// applies host writes and engine completions. When a set and a clear
// hit the same bit in one cycle, the set wins.
// Assumes fin_ok and fin_ab are never high together.
module can_tx_mbox_bank
    import can_tx_arb_pkg::*;
#(
    parameter  int NUM_MBOX = 32,
    parameter  int PRIO_W   = 6,
    localparam int IDX_W    = $clog2(NUM_MBOX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_sel,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [NUM_MBOX-1:0] cfg_wdata,
    input  logic                fin_ok,
    input  logic                fin_ab,
    input  logic [IDX_W-1:0]    fin_idx,
    output logic [NUM_MBOX-1:0] elig,
    output logic [NUM_MBOX-1:0] req_q,
    output logic [NUM_MBOX-1:0] ack_q,
    output logic [NUM_MBOX-1:0] abt_q,
    output logic [PRIO_W-1:0]   prio_q [NUM_MBOX]
);

    cfg_sel_e            sel;
    logic [NUM_MBOX-1:0] en_q;
    logic [NUM_MBOX-1:0] dir_q;
    logic [NUM_MBOX-1:0] fin_mask;
    logic [NUM_MBOX-1:0] set_mask;
    logic [NUM_MBOX-1:0] ack_clr;
    logic [NUM_MBOX-1:0] abt_clr;

    assign sel = cfg_sel_e'(cfg_sel);

    // Decode host write masks and the one-hot completion mask.
    always_comb begin
        fin_mask = '0;
        if (fin_ok || fin_ab) begin
            fin_mask[fin_idx] = 1'b1;
        end
        set_mask = (cfg_we && sel == SEL_REQ_SET) ? cfg_wdata : '0;
        ack_clr  = (cfg_we && sel == SEL_ACK_CLR) ? cfg_wdata : '0;
        abt_clr  = (cfg_we && sel == SEL_ABT_CLR) ? cfg_wdata : '0;
    end

    // Mailbox may compete: enabled, transmit direction, request pending.
    assign elig = en_q & ~dir_q & req_q;

    // Update all per-mailbox flags; set terms are ORed in after clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            dir_q <= '0;
            req_q <= '0;
            ack_q <= '0;
            abt_q <= '0;
        end else begin
            if (cfg_we && sel == SEL_ENABLE) begin
                en_q <= cfg_wdata;
            end
            if (cfg_we && sel == SEL_DIR) begin
                dir_q <= cfg_wdata;
            end
            req_q <= (req_q & ~fin_mask) | set_mask;
            ack_q <= (ack_q & ~ack_clr) | (fin_ok ? fin_mask : '0);
            abt_q <= (abt_q & ~abt_clr) | (fin_ab ? fin_mask : '0);
        end
    end

    // Capture the priority field of a control-word write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_MBOX; i++) begin
            if (!rst_n) begin
                prio_q[i] <= '0;
            end else if (cfg_we && sel == SEL_CTRL && cfg_idx == IDX_W'(i)) begin
                prio_q[i] <= cfg_wdata[PRIO_LSB +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/can_tx_prio_tree.sv
`timescale 1ns/1ps
// Module: combinational comparison tree. Each leaf key is
// {eligible, priority}. At every node the larger key wins, and on a
// tie the right child (higher mailbox numbers) wins, so equal
// priorities resolve to the highest index.
// Assumes NUM_MBOX is a power of two and at least 2.
module can_tx_prio_tree #(
    parameter  int NUM_MBOX = 32,
    parameter  int PRIO_W   = 6,
    localparam int IDX_W    = $clog2(NUM_MBOX),
    localparam int KEY_W    = PRIO_W + 1,
    localparam int LVL      = $clog2(NUM_MBOX)
) (
    input  logic [NUM_MBOX-1:0] elig,
    input  logic [PRIO_W-1:0]   prio [NUM_MBOX],
    output logic                any_elig,
    output logic [IDX_W-1:0]    win_idx
);

    // Levels 0..LVL-1 keep full keys; level 0 holds the leaves.
    for (genvar l = 0; l < LVL; l++) begin : g_lv
        localparam int CNT = NUM_MBOX >> l;
        logic [KEY_W-1:0] k [CNT];
        logic [IDX_W-1:0] x [CNT];
        if (l == 0) begin : g_leaf
            for (genvar j = 0; j < CNT; j++) begin : g_j
                assign k[j] = {elig[j], prio[j]};
                assign x[j] = IDX_W'(j);
            end
        end else begin : g_node
            for (genvar n = 0; n < CNT; n++) begin : g_n
                logic take_r;
                assign take_r = g_lv[l-1].k[2*n+1] >= g_lv[l-1].k[2*n];
                assign k[n]   = take_r ? g_lv[l-1].k[2*n+1] : g_lv[l-1].k[2*n];
                assign x[n]   = take_r ? g_lv[l-1].x[2*n+1] : g_lv[l-1].x[2*n];
            end
        end
    end

    // Root node: only the eligible bit and the index leave the tree.
    logic root_take_r;
    assign root_take_r = g_lv[LVL-1].k[1] >= g_lv[LVL-1].k[0];
    assign any_elig    = root_take_r ? g_lv[LVL-1].k[1][KEY_W-1] : g_lv[LVL-1].k[0][KEY_W-1];
    assign win_idx     = root_take_r ? g_lv[LVL-1].x[1] : g_lv[LVL-1].x[0];

endmodule

// File: rtl/can_tx_grant_seq.sv
`timescale 1ns/1ps
// Module: grant sequencer. In idle it latches the tree winner when any
// mailbox is eligible. It holds that grant until the engine reports
// done or abort, then returns to idle for one cycle. A done takes
// precedence over a simultaneous abort.
module can_tx_grant_seq
    import can_tx_arb_pkg::*;
#(
    parameter  int NUM_MBOX = 32,
    localparam int IDX_W    = $clog2(NUM_MBOX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_elig,
    input  logic [IDX_W-1:0] win_idx,
    input  logic             eng_done,
    input  logic             eng_abort,
    output logic             busy,
    output logic [IDX_W-1:0] gidx,
    output logic             fin_ok,
    output logic             fin_ab
);

    grant_state_e state_q;

    // Latch a winner when idle, release on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
            gidx    <= '0;
        end else if (state_q == GS_BUSY) begin
            if (eng_done || eng_abort) begin
                state_q <= GS_IDLE;
            end
        end else if (any_elig) begin
            state_q <= GS_BUSY;
            gidx    <= win_idx;
        end
    end

    // Qualify engine pulses with an active grant.
    assign busy   = (state_q == GS_BUSY);
    assign fin_ok = busy && eng_done;
    assign fin_ab = busy && eng_abort && !eng_done;

endmodule

// File: rtl/can_tx_arbiter.sv
`timescale 1ns/1ps
// Module: transmit mailbox priority arbiter (top). Connects the
// mailbox bank, the priority tree and the grant sequencer. The engine
// sees a level grant with a stable index, and the host sees request,
// acknowledge and abort-acknowledge vectors.
// Assumes NUM_MBOX is a power of two, at least 16.
module can_tx_arbiter
    import can_tx_arb_pkg::*;
#(
    parameter  int NUM_MBOX = 32,
    parameter  int PRIO_W   = 6,
    localparam int IDX_W    = $clog2(NUM_MBOX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_sel,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [NUM_MBOX-1:0] cfg_wdata,
    input  logic                eng_done,
    input  logic                eng_abort,
    output logic                grant_valid,
    output logic [IDX_W-1:0]    grant_idx,
    output logic [NUM_MBOX-1:0] req_flags,
    output logic [NUM_MBOX-1:0] ack_flags,
    output logic [NUM_MBOX-1:0] abt_flags
);

    logic [NUM_MBOX-1:0] elig;
    logic [PRIO_W-1:0]   prio [NUM_MBOX];
    logic                any_elig;
    logic [IDX_W-1:0]    win_idx;
    logic                fin_ok;
    logic                fin_ab;

    can_tx_mbox_bank #(.NUM_MBOX(NUM_MBOX), .PRIO_W(PRIO_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .fin_ok    (fin_ok),
        .fin_ab    (fin_ab),
        .fin_idx   (grant_idx),
        .elig      (elig),
        .req_q     (req_flags),
        .ack_q     (ack_flags),
        .abt_q     (abt_flags),
        .prio_q    (prio)
    );

    can_tx_prio_tree #(.NUM_MBOX(NUM_MBOX), .PRIO_W(PRIO_W)) u_tree (
        .elig     (elig),
        .prio     (prio),
        .any_elig (any_elig),
        .win_idx  (win_idx)
    );

    can_tx_grant_seq #(.NUM_MBOX(NUM_MBOX)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_elig  (any_elig),
        .win_idx   (win_idx),
        .eng_done  (eng_done),
        .eng_abort (eng_abort),
        .busy      (grant_valid),
        .gidx      (grant_idx),
        .fin_ok    (fin_ok),
        .fin_ab    (fin_ab)
    );

endmodule

// File: rtl/can_tx_arbiter_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for can_tx_arbiter, attached by bind.
// It observes only the top-level ports.
module can_tx_arbiter_chk #(
    parameter  int NUM_MBOX = 32,
    localparam int IDX_W    = $clog2(NUM_MBOX)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_we,
    input logic [2:0]          cfg_sel,
    input logic [NUM_MBOX-1:0] cfg_wdata,
    input logic                eng_done,
    input logic                eng_abort,
    input logic                grant_valid,
    input logic [IDX_W-1:0]    grant_idx,
    input logic [NUM_MBOX-1:0] req_flags,
    input logic [NUM_MBOX-1:0] ack_flags,
    input logic [NUM_MBOX-1:0] abt_flags
);

    // R1: a newly granted mailbox has a pending request
    a_r1_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> req_flags[grant_idx]);

    // R4: done sets the acknowledge bit of the granted mailbox
    a_r4_ack_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && eng_done) |=> ack_flags[$past(grant_idx)]);

    // R4: done clears the request unless the host sets it in the same cycle
    a_r4_req_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && eng_done && !(cfg_we && cfg_sel == 3'd2 && cfg_wdata[grant_idx]))
        |=> !req_flags[$past(grant_idx)]);

    // R7: a lone abort sets the abort-acknowledge bit
    a_r7_abort_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && eng_abort && !eng_done) |=> abt_flags[$past(grant_idx)]);

    // R8: the grant holds while the frame is in flight
    a_r8_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !eng_done && !eng_abort) |=> (grant_valid && $stable(grant_idx)));

    // R9: after a completion the grant drops for a cycle
    a_r9_gap_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && (eng_done || eng_abort)) |=> !grant_valid);

endmodule

bind can_tx_arbiter can_tx_arbiter_chk #(.NUM_MBOX(NUM_MBOX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .eng_done    (eng_done),
    .eng_abort   (eng_abort),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .req_flags   (req_flags),
    .ack_flags   (ack_flags),
    .abt_flags   (abt_flags)
);

// File: tb/can_tx_arbiter_test.sv
`timescale 1ns/1ps
// Directed bench for can_tx_arbiter. One task per scenario.
// Inputs are driven and outputs sampled on the falling edge.
module can_tx_arbiter_test;

    localparam int N  = 32;
    localparam int IW = 5;
    localparam logic [2:0] S_EN = 3'd0, S_DIR = 3'd1, S_REQ = 3'd2,
                           S_ACK = 3'd3, S_ABT = 3'd4, S_CTRL = 3'd5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [IW-1:0] cfg_idx = '0;
    logic [N-1:0]  cfg_wdata = '0;
    logic          eng_done = 1'b0;
    logic          eng_abort = 1'b0;
    logic          grant_valid;
    logic [IW-1:0] grant_idx;
    logic [N-1:0]  req_flags, ack_flags, abt_flags;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    can_tx_arbiter #(.NUM_MBOX(N), .PRIO_W(6)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .eng_done(eng_done),
        .eng_abort(eng_abort), .grant_valid(grant_valid), .grant_idx(grant_idx),
        .req_flags(req_flags), .ack_flags(ack_flags), .abt_flags(abt_flags)
    );

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] sel, int idx, logic [N-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = IW'(idx); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic set_prio(int idx, int p);
        wr(S_CTRL, idx, N'(p) << 8);
    endtask

    task automatic wait_grant();
        for (int i = 0; i < 8; i++) begin
            if (grant_valid) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_frame(bit ab);
        @(negedge clk);
        if (ab) eng_abort = 1'b1; else eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0; eng_abort = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R9 reset valid", grant_valid, 0);
        check("R6 reset req", req_flags, 0);
        check("R5 reset ack", ack_flags, 0);
        check("R7 reset abt", abt_flags, 0);
    endtask

    task automatic t_eligibility();
        do_reset();
        set_prio(2, 10);
        wr(S_EN, 0, 32'h0000_0004);
        wr(S_DIR, 0, 32'h0000_0004);
        wr(S_REQ, 0, 32'h0000_0044);
        repeat (4) @(negedge clk);
        check("R1 receive/disabled not granted", grant_valid, 0);
        check("R1 requests still pending", req_flags, 32'h44);
        wr(S_DIR, 0, 32'h0);
        wait_grant();
        check("R1 grant after direction to transmit", grant_valid, 1);
        check("R1 grant index", grant_idx, 2);
        finish_frame(1'b0);
        repeat (3) @(negedge clk);
        check("R9 disabled mailbox never granted", grant_valid, 0);
    endtask

    task automatic t_priority();
        do_reset();
        set_prio(3, 10); set_prio(7, 40); set_prio(20, 5);
        wr(S_EN, 0, 32'h0010_0088);
        wr(S_REQ, 0, 32'h0010_0088);
        wait_grant();
        check("R2 highest priority first", grant_idx, 7);
        finish_frame(1'b0);
        check("R9 gap after done", grant_valid, 0);
        check("R4 ack set on done", ack_flags, 32'h80);
        check("R4 request cleared", req_flags, 32'h0010_0008);
        wait_grant();
        check("R2 second priority", grant_idx, 3);
        finish_frame(1'b0);
        wait_grant();
        check("R2 lowest priority last", grant_idx, 20);
        finish_frame(1'b0);
        repeat (3) @(negedge clk);
        check("R9 idle when none eligible", grant_valid, 0);
        check("R4 all acks", ack_flags, 32'h0010_0088);
    endtask

    task automatic t_tie();
        do_reset();
        set_prio(1, 63); set_prio(4, 63); set_prio(9, 63); set_prio(30, 62);
        wr(S_EN, 0, 32'h4000_0212);
        wr(S_REQ, 0, 32'h4000_0212);
        wait_grant();
        check("R3 tie highest index", grant_idx, 9);
        finish_frame(1'b0);
        wait_grant();
        check("R3 tie next index", grant_idx, 4);
        finish_frame(1'b0);
        wait_grant();
        check("R3 tie lowest index", grant_idx, 1);
        finish_frame(1'b0);
        wait_grant();
        check("R2 lower priority after tie group", grant_idx, 30);
        finish_frame(1'b0);
        @(negedge clk);
        wr(S_ACK, 0, 32'h0);
        check("R5 zero write keeps acks", ack_flags, 32'h4000_0212);
        wr(S_ACK, 0, 32'h0000_0010);
        check("R5 one clears ack bit", ack_flags, 32'h4000_0202);
    endtask

    task automatic t_reqset();
        do_reset();
        wr(S_REQ, 0, 32'h0000_0011);
        check("R6 set bits", req_flags, 32'h11);
        wr(S_REQ, 0, 32'h0);
        check("R6 zero write keeps requests", req_flags, 32'h11);
        wr(S_REQ, 0, 32'h0000_0100);
        check("R6 additional set", req_flags, 32'h111);
    endtask

    task automatic t_abort();
        do_reset();
        set_prio(12, 1);
        wr(S_EN, 0, 32'h0000_1000);
        wr(S_REQ, 0, 32'h0000_1000);
        wait_grant();
        check("R7 grant before abort", grant_idx, 12);
        finish_frame(1'b1);
        check("R7 abort flag", abt_flags, 32'h1000);
        check("R7 no ack on abort", ack_flags, 0);
        check("R7 request cleared", req_flags, 0);
        set_prio(13, 1);
        wr(S_EN, 0, 32'h0000_2000);
        wr(S_REQ, 0, 32'h0000_2000);
        wait_grant();
        @(negedge clk);
        eng_done = 1'b1; eng_abort = 1'b1;
        @(negedge clk);
        eng_done = 1'b0; eng_abort = 1'b0;
        check("R7 done wins over abort ack", ack_flags, 32'h2000);
        check("R7 done wins over abort abt", abt_flags, 32'h1000);
        wr(S_ABT, 0, 32'h0000_1000);
        check("R7 abort-ack clear", abt_flags, 0);
    endtask

    task automatic t_hold();
        do_reset();
        set_prio(7, 20); set_prio(3, 10);
        wr(S_EN, 0, 32'h0000_0088);
        wr(S_REQ, 0, 32'h0000_0088);
        wait_grant();
        check("R8 initial grant", grant_idx, 7);
        set_prio(3, 63);
        set_prio(7, 0);
        repeat (2) @(negedge clk);
        check("R8 valid held", grant_valid, 1);
        check("R8 index held", grant_idx, 7);
        finish_frame(1'b0);
        wait_grant();
        check("R8 new priority used next", grant_idx, 3);
        finish_frame(1'b0);
    endtask

    task automatic t_collide();
        do_reset();
        set_prio(5, 1);
        wr(S_EN, 0, 32'h0000_0020);
        wr(S_REQ, 0, 32'h0000_0020);
        wait_grant();
        @(negedge clk);
        eng_done = 1'b1;
        cfg_we = 1'b1; cfg_sel = S_REQ; cfg_wdata = 32'h0000_0020;
        @(negedge clk);
        eng_done = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        check("R10 request set beats completion clear", req_flags, 32'h20);
        check("R10 ack still set", ack_flags, 32'h20);
        wait_grant();
        check("R10 mailbox regranted", grant_idx, 5);
        @(negedge clk);
        eng_done = 1'b1;
        cfg_we = 1'b1; cfg_sel = S_ACK; cfg_wdata = 32'h0000_0020;
        @(negedge clk);
        eng_done = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        check("R10 ack set beats ack clear", ack_flags, 32'h20);
        check("R10 request cleared after second frame", req_flags, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_eligibility();
        t_priority();
        t_tie();
        t_reqset();
        t_abort();
        t_hold();
        t_collide();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule